// File: doc/BRIEF.md
# Bus Master Write Wrapper with Per-Command Buffer Selection

This block sits between an IP core and a split command/write-data bus channel. The core hands it one command at a time through a valid/ready request handshake, with a separate valid/ready stream for write beats. The wrapper puts the command on the bus as a request with address, command code, size, a command identifier and a fixed master identifier. It then waits for the slave to accept (ACK) or refuse (NACK).

For every write the wrapper picks one of two data paths. The choice depends on how the transfer length compares with a small local buffer. A write that fits is pulled from the core into the buffer before the bus request is raised. Its beats go out on the bus from the first cycle after the ACK, back to back. A write that does not fit skips the buffer. The core's write stream is held off until the ACK, and from then on each core beat passes straight through to the bus. A refused request is raised again after a one-cycle gap and keeps its identifier. Buffered data stays where it is.

Top module: `mwr_wrap`

## Requirements
- R1: While reset is asserted and after it is released, with no command offered: core_req_ready_o is 1, and cwd_req_o, cwd_wvalid_o and core_wd_ready_o are 0.
- R2: The 3-bit size code 0,1,2,3,4 means 8,16,32,64,128 bytes. A command moves (bytes/8) beats of 64 bits. The request shows the core's size code, and cwd_wlast_o is 1 only on the final beat.
- R3: A write whose byte count is at most BUF_BYTES is buffered. The wrapper takes all of its beats from the core, with core_wd_ready_o high and cwd_req_o low, before it raises cwd_req_o.
- R4: For a buffered write, cwd_wvalid_o stays 0 in the ACK cycle. It is 1 in each of the consecutive cycles that follow, carrying the captured beats in the order they were taken.
- R5: For a write larger than BUF_BYTES, core_wd_ready_o stays 0 until the ACK. In the following cycles core_wd_ready_o is 1 and each cycle's core beat appears on cwd_wvalid_o/cwd_wdata_o in that same cycle. A cycle with no core beat gives no bus beat.
- R6: After a NACK, cwd_req_o is 0 for exactly one cycle and then returns with the same address and command ID. No write data is fetched from the core during the retry.
- R7: Each accepted command takes the next command ID (starting at 0 after reset, wrapping modulo 2^CID_W). cwd_mid_o always equals MASTER_ID.
- R8: Only one command is in flight. core_req_ready_o is 0 from acceptance until the cycle after the last write beat is sent (or after the ACK of a read), and is 1 in that cycle.
- R9: A read command (core_req_write_i = 0) is issued with command code 0 and moves no write data. The wrapper is free again in the cycle after its ACK.
- R10: The command code on cwd_cmd_o is 1 for writes and 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| core_req_valid_i | input | 1 | Core offers a command |
| core_req_ready_o | output | 1 | Wrapper accepts a command |
| core_req_write_i | input | 1 | 1 = write, 0 = read |
| core_req_addr_i | input | ADDR_W | Command address |
| core_req_size_i | input | 3 | Size code (0..4 = 8..128 bytes) |
| core_wd_valid_i | input | 1 | Core write beat valid |
| core_wd_ready_o | output | 1 | Wrapper takes the write beat |
| core_wd_data_i | input | DATA_W | Core write beat |
| cwd_req_o | output | 1 | Bus request |
| cwd_addr_o | output | ADDR_W | Request address |
| cwd_cmd_o | output | 1 | Command code (1 write, 0 read) |
| cwd_size_o | output | 3 | Size code |
| cwd_cid_o | output | CID_W | Command ID |
| cwd_mid_o | output | MID_W | Master ID |
| cwd_wvalid_o | output | 1 | Write beat valid on bus |
| cwd_wdata_o | output | DATA_W | Write beat on bus |
| cwd_wlast_o | output | 1 | Final write beat |
| cwd_ack_i | input | 1 | Slave accepts request |
| cwd_nack_i | input | 1 | Slave refuses request |

## Verification
The bench aims at both sides of the buffer threshold: a size that just fits goes one way and the next size up goes the other. A wrong comparison would either stall a large write with no room or stream a small one before its ACK. NACK retries are run on both paths. A design that lost the buffer contents or fetched from the core again would show wrong bus data, or core_wd_ready_o high during the retry. A one-cycle core stall in the middle of a bypass stream checks that no phantom bus beat is created. A long run of reads checks that the command ID wraps.

// File: rtl/mwrap_pkg.sv
package mwrap_pkg;

  localparam int unsigned MAX_BEATS = 16;
  localparam int unsigned CNT_W     = $clog2(MAX_BEATS);

  localparam logic CMD_READ  = 1'b0;
  localparam logic CMD_WRITE = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_REQ,
    ST_GAP,
    ST_SEND,
    ST_STREAM
  } mw_state_e;

  function automatic int unsigned bytes_of(input logic [2:0] code);
    return 32'd8 << code;
  endfunction

endpackage

// File: rtl/mwrap_rst_sync.sv
module mwrap_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/mwrap_wbuf.sv
module mwrap_wbuf #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned IDX_W  = 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && (widx_i == IDX_W'(g))) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];

endmodule

// File: rtl/mwrap_wmux.sv
module mwrap_wmux #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              sel_core_i,
  input  logic [DATA_W-1:0] core_data_i,
  input  logic [DATA_W-1:0] buf_data_i,
  output logic [DATA_W-1:0] bus_data_o
);

  assign bus_data_o = sel_core_i ? core_data_i : buf_data_i;

endmodule

// File: rtl/mwrap_ctrl.sv
module mwrap_ctrl
  import mwrap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CID_W     = 4,
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned IDX_W     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_size_i,
  input  logic              wd_valid_i,
  output logic              wd_ready_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_cmd_o,
  output logic [2:0]        bus_size_o,
  output logic [CID_W-1:0]  bus_cid_o,
  output logic              bus_wvalid_o,
  output logic              bus_wlast_o,
  input  logic              bus_ack_i,
  input  logic              bus_nack_i,
  output logic              buf_we_o,
  output logic [IDX_W-1:0]  buf_idx_o,
  output logic              sel_core_o
);

  mw_state_e         st_q, st_d;
  logic              wr_q, wr_d;
  logic              buffered_q, buffered_d;
  logic [2:0]        size_q, size_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CID_W-1:0]  cid_q, cid_d;
  logic [CID_W-1:0]  alloc_q, alloc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  last_idx;
  logic              at_last;
  logic              fits;

  assign last_idx = CNT_W'((5'd1 << size_q) - 5'd1);
  assign at_last  = (cnt_q == last_idx);
  assign fits     = (bytes_of(req_size_i) <= BUF_BYTES);

  always_comb begin
    st_d         = st_q;
    wr_d         = wr_q;
    buffered_d   = buffered_q;
    size_d       = size_q;
    addr_d       = addr_q;
    cid_d        = cid_q;
    alloc_d      = alloc_q;
    cnt_d        = cnt_q;
    req_ready_o  = 1'b0;
    wd_ready_o   = 1'b0;
    bus_req_o    = 1'b0;
    bus_wvalid_o = 1'b0;
    bus_wlast_o  = 1'b0;
    buf_we_o     = 1'b0;
    sel_core_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        req_ready_o = 1'b1;
        if (req_valid_i) begin
          wr_d       = req_write_i;
          buffered_d = req_write_i && fits;
          size_d     = req_size_i;
          addr_d     = req_addr_i;
          cid_d      = alloc_q;
          alloc_d    = alloc_q + 1'b1;
          cnt_d      = '0;
          st_d       = (req_write_i && fits) ? ST_FILL : ST_REQ;
        end
      end
      ST_FILL: begin
        wd_ready_o = 1'b1;
        buf_we_o   = wd_valid_i;
        if (wd_valid_i) begin
          cnt_d = cnt_q + 1'b1;
          if (at_last) st_d = ST_REQ;
        end
      end
      ST_REQ: begin
        bus_req_o = 1'b1;
        if (bus_ack_i) begin
          cnt_d = '0;
          if (!wr_q)          st_d = ST_IDLE;
          else if (buffered_q) st_d = ST_SEND;
          else                 st_d = ST_STREAM;
        end else if (bus_nack_i) begin
          st_d = ST_GAP;
        end
      end
      ST_GAP: begin
        st_d = ST_REQ;
      end
      ST_SEND: begin
        bus_wvalid_o = 1'b1;
        bus_wlast_o  = at_last;
        cnt_d        = cnt_q + 1'b1;
        if (at_last) st_d = ST_IDLE;
      end
      ST_STREAM: begin
        wd_ready_o   = 1'b1;
        sel_core_o   = 1'b1;
        bus_wvalid_o = wd_valid_i;
        bus_wlast_o  = wd_valid_i && at_last;
        if (wd_valid_i) begin
          cnt_d = cnt_q + 1'b1;
          if (at_last) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      wr_q       <= CMD_READ;
      buffered_q <= 1'b0;
      size_q     <= '0;
      addr_q     <= '0;
      cid_q      <= '0;
      alloc_q    <= '0;
      cnt_q      <= '0;
    end else begin
      st_q       <= st_d;
      wr_q       <= wr_d;
      buffered_q <= buffered_d;
      size_q     <= size_d;
      addr_q     <= addr_d;
      cid_q      <= cid_d;
      alloc_q    <= alloc_d;
      cnt_q      <= cnt_d;
    end
  end

  assign bus_addr_o = addr_q;
  assign bus_cmd_o  = wr_q;
  assign bus_size_o = size_q;
  assign bus_cid_o  = cid_q;
  assign buf_idx_o  = cnt_q[IDX_W-1:0];

endmodule

// File: rtl/mwr_wrap.sv
module mwr_wrap #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned CID_W     = 4,
  parameter int unsigned MID_W     = 3,
  parameter int unsigned MASTER_ID = 5,
  parameter int unsigned BUF_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_req_valid_i,
  output logic              core_req_ready_o,
  input  logic              core_req_write_i,
  input  logic [ADDR_W-1:0] core_req_addr_i,
  input  logic [2:0]        core_req_size_i,
  input  logic              core_wd_valid_i,
  output logic              core_wd_ready_o,
  input  logic [DATA_W-1:0] core_wd_data_i,
  output logic              cwd_req_o,
  output logic [ADDR_W-1:0] cwd_addr_o,
  output logic              cwd_cmd_o,
  output logic [2:0]        cwd_size_o,
  output logic [CID_W-1:0]  cwd_cid_o,
  output logic [MID_W-1:0]  cwd_mid_o,
  output logic              cwd_wvalid_o,
  output logic [DATA_W-1:0] cwd_wdata_o,
  output logic              cwd_wlast_o,
  input  logic              cwd_ack_i,
  input  logic              cwd_nack_i
);

  localparam int unsigned RAW_DEPTH = BUF_BYTES / 8;
  localparam int unsigned BUF_DEPTH = (RAW_DEPTH < 2) ? 2 : RAW_DEPTH;
  localparam int unsigned IDX_W     = $clog2(BUF_DEPTH);

  logic              rst_n_q;
  logic              buf_we;
  logic [IDX_W-1:0]  buf_idx;
  logic [DATA_W-1:0] buf_rdata;
  logic              sel_core;

  mwrap_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  mwrap_ctrl #(
    .ADDR_W    (ADDR_W),
    .CID_W     (CID_W),
    .BUF_BYTES (BUF_BYTES),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_q),
    .req_valid_i  (core_req_valid_i),
    .req_ready_o  (core_req_ready_o),
    .req_write_i  (core_req_write_i),
    .req_addr_i   (core_req_addr_i),
    .req_size_i   (core_req_size_i),
    .wd_valid_i   (core_wd_valid_i),
    .wd_ready_o   (core_wd_ready_o),
    .bus_req_o    (cwd_req_o),
    .bus_addr_o   (cwd_addr_o),
    .bus_cmd_o    (cwd_cmd_o),
    .bus_size_o   (cwd_size_o),
    .bus_cid_o    (cwd_cid_o),
    .bus_wvalid_o (cwd_wvalid_o),
    .bus_wlast_o  (cwd_wlast_o),
    .bus_ack_i    (cwd_ack_i),
    .bus_nack_i   (cwd_nack_i),
    .buf_we_o     (buf_we),
    .buf_idx_o    (buf_idx),
    .sel_core_o   (sel_core)
  );

  mwrap_wbuf #(
    .DATA_W (DATA_W),
    .DEPTH  (BUF_DEPTH),
    .IDX_W  (IDX_W)
  ) u_wbuf (
    .clk_i   (clk_i),
    .we_i    (buf_we),
    .widx_i  (buf_idx),
    .wdata_i (core_wd_data_i),
    .ridx_i  (buf_idx),
    .rdata_o (buf_rdata)
  );

  mwrap_wmux #(
    .DATA_W (DATA_W)
  ) u_wmux (
    .sel_core_i  (sel_core),
    .core_data_i (core_wd_data_i),
    .buf_data_i  (buf_rdata),
    .bus_data_o  (cwd_wdata_o)
  );

  assign cwd_mid_o = MID_W'(MASTER_ID);

endmodule

// File: rtl/mwrap_chk.sv
module mwrap_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CID_W     = 4,
  parameter int unsigned BUF_BYTES = 16
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              req_ready,
  input logic              wd_ready,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_cmd,
  input logic [2:0]        bus_size,
  input logic [CID_W-1:0]  bus_cid,
  input logic              bus_wvalid,
  input logic              bus_wlast,
  input logic              bus_ack,
  input logic              bus_nack
);

  logic fits;
  assign fits = ((32'd8 << bus_size) <= BUF_BYTES);

  p_buf_next_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_req && bus_ack && bus_cmd && fits) |=> (bus_wvalid && !wd_ready));

  p_byp_open_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_req && bus_ack && bus_cmd && !fits) |=> wd_ready);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    bus_req |-> (!wd_ready && !bus_wvalid));

  p_nack_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_req && bus_nack && !bus_ack) |=> (!bus_req && !wd_ready && $stable(bus_cid) && $stable(bus_addr)));

  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_req || (bus_wvalid && !bus_wlast)) |-> !req_ready);

  p_free_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_wvalid && bus_wlast) |=> req_ready);

  p_read_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_cmd) |=> (!bus_wvalid && req_ready));

endmodule

bind mwr_wrap mwrap_chk #(
  .ADDR_W    (ADDR_W),
  .CID_W     (CID_W),
  .BUF_BYTES (BUF_BYTES)
) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_q),
  .req_ready  (core_req_ready_o),
  .wd_ready   (core_wd_ready_o),
  .bus_req    (cwd_req_o),
  .bus_addr   (cwd_addr_o),
  .bus_cmd    (cwd_cmd_o),
  .bus_size   (cwd_size_o),
  .bus_cid    (cwd_cid_o),
  .bus_wvalid (cwd_wvalid_o),
  .bus_wlast  (cwd_wlast_o),
  .bus_ack    (cwd_ack_i),
  .bus_nack   (cwd_nack_i)
);

// File: tb/mwr_wrap_bench.sv
`timescale 1ns/1ps
module mwr_wrap_bench;

  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned CID_W     = 4;
  localparam int unsigned MID_W     = 3;
  localparam int unsigned MASTER_ID = 5;
  localparam int unsigned BUF_BYTES = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              req_valid, req_ready, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [2:0]        req_size;
  logic              wd_valid, wd_ready;
  logic [DATA_W-1:0] wd_data;
  logic              bus_req, bus_cmd, bus_wvalid, bus_wlast, bus_ack, bus_nack;
  logic [ADDR_W-1:0] bus_addr;
  logic [2:0]        bus_size;
  logic [CID_W-1:0]  bus_cid;
  logic [MID_W-1:0]  bus_mid;
  logic [DATA_W-1:0] bus_wdata;

  mwr_wrap #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CID_W(CID_W), .MID_W(MID_W),
    .MASTER_ID(MASTER_ID), .BUF_BYTES(BUF_BYTES)
  ) u_mwr_wrap (
    .clk_i(clk), .rst_ni(rst_n),
    .core_req_valid_i(req_valid), .core_req_ready_o(req_ready),
    .core_req_write_i(req_write), .core_req_addr_i(req_addr), .core_req_size_i(req_size),
    .core_wd_valid_i(wd_valid), .core_wd_ready_o(wd_ready), .core_wd_data_i(wd_data),
    .cwd_req_o(bus_req), .cwd_addr_o(bus_addr), .cwd_cmd_o(bus_cmd), .cwd_size_o(bus_size),
    .cwd_cid_o(bus_cid), .cwd_mid_o(bus_mid), .cwd_wvalid_o(bus_wvalid),
    .cwd_wdata_o(bus_wdata), .cwd_wlast_o(bus_wlast),
    .cwd_ack_i(bus_ack), .cwd_nack_i(bus_nack)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit reported = 1'b0;
  logic [CID_W-1:0] exp_cid = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    end
    $finish;
  endtask

  function automatic logic [63:0] pat(input int tag, input int i);
    return 64'hC3A5_0000_0000_0000 ^ (64'(tag) << 16) ^ 64'(i * 3 + 1);
  endfunction

  task automatic offer(input logic wr, input logic [2:0] sz, input logic [31:0] a);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
    #1;
    check("R8 ready when idle", req_ready, 1);
    tick();
    req_valid = 1'b0;
  endtask

  task automatic check_req(input logic wr, input logic [2:0] sz, input logic [31:0] a);
    check("R3/R9 request raised", bus_req, 1);
    check("R10 command code", bus_cmd, wr);
    check("R2 size code", bus_size, sz);
    check("R7 command id", bus_cid, exp_cid);
    check("R7 master id", bus_mid, MASTER_ID);
    check("R6 address", bus_addr, a);
    check("R8 busy during request", req_ready, 0);
  endtask

  task automatic do_nack();
    bus_nack = 1'b1;
    tick();
    bus_nack = 1'b0;
    #1;
    check("R6 request dropped after nack", bus_req, 0);
    check("R6 no core fetch in gap", wd_ready, 0);
    tick();
    #1;
    check("R6 request back", bus_req, 1);
    check("R6 same id on retry", bus_cid, exp_cid);
    check("R6 no core fetch on retry", wd_ready, 0);
  endtask

  task automatic t_buffered(input logic [2:0] sz, input bit nack, input int tag);
    int n = 1 << sz;
    logic [31:0] a = 32'h1000_0000 + 32'(tag * 256);
    offer(1'b1, sz, a);
    for (int i = 0; i < n; i++) begin
      wd_valid = 1'b1; wd_data = pat(tag, i);
      #1;
      check("R3 buffer fill ready", wd_ready, 1);
      check("R3 no request while filling", bus_req, 0);
      tick();
    end
    wd_valid = 1'b0;
    #1;
    check_req(1'b1, sz, a);
    if (nack) begin
      tick();
      do_nack();
    end
    tick();
    bus_ack = 1'b1;
    #1;
    check("R4 no data in ack cycle", bus_wvalid, 0);
    tick();
    bus_ack = 1'b0;
    for (int i = 0; i < n; i++) begin
      #1;
      check("R4 buffered beat valid", bus_wvalid, 1);
      check("R4 buffered beat data", bus_wdata, pat(tag, i));
      check("R2 last flag", bus_wlast, (i == n - 1));
      check("R4 core not fetched", wd_ready, 0);
      check("R8 busy while sending", req_ready, 0);
      tick();
    end
    #1;
    check("R8 free after last beat", req_ready, 1);
    check("R4 no extra beat", bus_wvalid, 0);
    exp_cid++;
    tick();
  endtask

  task automatic t_bypass(input logic [2:0] sz, input bit nack, input int tag);
    int n = 1 << sz;
    logic [31:0] a = 32'h2000_0000 + 32'(tag * 256);
    offer(1'b1, sz, a);
    wd_valid = 1'b1; wd_data = pat(tag, 0);
    #1;
    check_req(1'b1, sz, a);
    check("R5 core held before ack", wd_ready, 0);
    check("R5 no bus data before ack", bus_wvalid, 0);
    if (nack) begin
      tick();
      do_nack();
    end
    tick();
    bus_ack = 1'b1;
    #1;
    check("R5 core held in ack cycle", wd_ready, 0);
    tick();
    bus_ack = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i == 1) begin
        wd_valid = 1'b0;
        #1;
        check("R5 stall gives no bus beat", bus_wvalid, 0);
        check("R5 ready during stall", wd_ready, 1);
        tick();
      end
      wd_valid = 1'b1; wd_data = pat(tag, i);
      #1;
      check("R5 stream ready", wd_ready, 1);
      check("R5 stream valid", bus_wvalid, 1);
      check("R5 stream data", bus_wdata, pat(tag, i));
      check("R2 last flag", bus_wlast, (i == n - 1));
      tick();
    end
    wd_valid = 1'b0;
    #1;
    check("R8 free after last beat", req_ready, 1);
    check("R5 stream closed", wd_ready, 0);
    exp_cid++;
    tick();
  endtask

  task automatic t_read(input logic [2:0] sz, input int tag);
    logic [31:0] a = 32'h3000_0000 + 32'(tag * 64);
    offer(1'b0, sz, a);
    #1;
    check_req(1'b0, sz, a);
    check("R9 no write fetch", wd_ready, 0);
    tick();
    bus_ack = 1'b1;
    tick();
    bus_ack = 1'b0;
    #1;
    check("R9 free after read ack", req_ready, 1);
    check("R9 no write data", bus_wvalid, 0);
    exp_cid++;
    tick();
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0;
    wd_valid = 1'b0; wd_data = '0; bus_ack = 1'b0; bus_nack = 1'b0;
    repeat (3) tick();
    check("R1 ready in reset", req_ready, 1);
    check("R1 no request in reset", bus_req, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 ready after reset", req_ready, 1);
    check("R1 no request", bus_req, 0);
    check("R1 no bus data", bus_wvalid, 0);
    check("R1 no core fetch", wd_ready, 0);

    t_buffered(3'd0, 1'b0, 1);
    t_buffered(3'd1, 1'b0, 2);
    t_buffered(3'd1, 1'b1, 3);
    t_bypass(3'd2, 1'b0, 4);
    t_bypass(3'd4, 1'b1, 5);
    t_bypass(3'd3, 1'b0, 6);
    t_read(3'd2, 7);
    for (int k = 0; k < 17; k++) t_read(3'(k % 5), 8 + k);
    t_buffered(3'd0, 1'b1, 30);
    report();
  end

endmodule